// File: doc/BRIEF.md
# Isochronous Per-Frame Packet Sizer

This block sits beside an isochronous audio endpoint whose sample clock runs free of the bus frame clock. It counts the sample strobes that arrive between two start-of-frame strobes. At each start-of-frame it decides how many samples the next packet carries, then turns that into a byte count for the packet builder. The frame period is 1 ms on full-speed links and 125 us on high-speed links. The nominal rate is usually fractional: a 44.1 kHz stereo stream gives 44.1 samples per millisecond, so packets move between 43 and 46 samples. An 8 kHz mono stream moves between 7 and 9 bytes.

The packet size is kept between a configured minimum and a configured maximum. Samples that do not fit, or a shortfall that had to be padded, go into a signed carry that feeds the next frame. The long-term rate therefore follows the sample clock, and the packet sizes themselves tell the receiver the source rate. Isochronous traffic is never retried. Every start-of-frame produces exactly one size, so the sizer stays aligned with the frame count even when a packet is lost on the bus. When the carry drifts beyond two samples in either direction, a sticky overrun or underrun flag reports that the slack is exhausted.

Top module: `iso_packet_sizer`

## Requirements
- R1: While reset is held and just after it, `pkt_valid_o`, `overrun_o` and `underrun_o` are 0, and the sample carry is 0.
- R2: Each cycle with `sof_i` high is followed by exactly one cycle with `pkt_valid_o` high. `pkt_valid_o` is low in every other cycle.
- R3: Sample strobes are counted from one start-of-frame to the next. A strobe in the same cycle as `sof_i` counts toward the following frame.
- R4: At a start-of-frame, the available count (samples counted plus carry) is clamped to the range from `spp_min_i` to `spp_max_i` to give the packet sample count.
- R5: The new carry is the available count minus the packet sample count. It is signed and saturates at plus or minus 31 with the default 6-bit carry. It changes only at a start-of-frame.
- R6: `pkt_bytes_o` equals the packet sample count times the `bps_i` value present in the start-of-frame cycle.
- R7: `overrun_o` sets when a start-of-frame leaves the carry above +2. It then stays set until cleared.
- R8: `underrun_o` sets when a start-of-frame leaves the carry below -2. It then stays set until cleared.
- R9: A `flag_clr_i` pulse clears both flags. If a start-of-frame sets a flag in the same cycle, the set wins.
- R10: The sample counter saturates at 255 with the default 8-bit width and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe, one cycle per frame |
| smp_tick_i | input | 1 | One-cycle strobe per produced sample, already synchronized |
| bps_i | input | 3 | Bytes per sample |
| spp_min_i | input | 8 | Minimum samples per packet |
| spp_max_i | input | 8 | Maximum samples per packet |
| flag_clr_i | input | 1 | Clears the overrun and underrun flags |
| pkt_valid_o | output | 1 | High for one cycle after each start-of-frame |
| pkt_bytes_o | output | 11 | Packet byte count, meaningful while `pkt_valid_o` is high |
| overrun_o | output | 1 | Sticky flag: the carry went above +2 |
| underrun_o | output | 1 | Sticky flag: the carry went below -2 |

## Verification
The assertions assume that `sof_i` is a single-cycle strobe and that the packet range is well formed, with `spp_min_i` no larger than `spp_max_i`. They also assume that the range and `bps_i` hold steady across a start-of-frame. The bench changes the configuration only between frames, always keeps the minimum at or below the maximum, and raises `sof_i` for one cycle at a time. Expected sizes come from an arithmetic model of the clamp and the carry, which is run over every bytes-per-sample value from 1 to 4 and over sample counts spread around the nominal rate.

// File: rtl/iso_sizer_pkg.sv
package iso_sizer_pkg;

    // Carry magnitude beyond which the slack is considered exhausted
    localparam int SLACK_LIMIT_DEF = 2;

    typedef struct packed {
        logic over;
        logic under;
    } iso_flags_t;

endpackage

// File: rtl/iso_tick_counter.sv
module iso_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof_i) begin
            // a strobe coinciding with the frame mark belongs to the next frame
            st_d.cnt = tick_i ? CNT_W'(1) : '0;
        end else if (tick_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && !tick_i) |=> $stable(st_q.cnt));

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (st_q.cnt <= CNT_W'(1)));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

endmodule

// File: rtl/iso_carry_clamp.sv
module iso_carry_clamp
    import iso_sizer_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CARRY_W = 6,
    parameter int LIMIT   = SLACK_LIMIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] min_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] send_o,
    output iso_flags_t       flags_o
);
    localparam int AW  = CNT_W + 2;
    localparam int SAT = (1 << (CARRY_W - 1)) - 1;
    localparam logic signed [AW-1:0] SAT_HI = AW'(SAT);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI;
    localparam logic signed [AW-1:0] LIM_HI = AW'(LIMIT);
    localparam logic signed [AW-1:0] LIM_LO = -LIM_HI;

    typedef struct packed {
        logic signed [CARRY_W-1:0] carry;
        iso_flags_t                flags;
    } clamp_state_t;

    clamp_state_t st_d, st_q;

    logic signed [AW-1:0] avail;
    logic signed [AW-1:0] lo_s;
    logic signed [AW-1:0] hi_s;
    logic signed [AW-1:0] send_s;
    logic signed [AW-1:0] diff;
    logic signed [AW-1:0] diff_sat;

    always_comb begin
        lo_s  = $signed({2'b00, min_i});
        hi_s  = $signed({2'b00, max_i});
        avail = $signed({2'b00, count_i})
              + $signed({{(AW-CARRY_W){st_q.carry[CARRY_W-1]}}, st_q.carry});

        if (avail > hi_s)      send_s = hi_s;
        else if (avail < lo_s) send_s = lo_s;
        else                   send_s = avail;

        diff = avail - send_s;
        if (diff > SAT_HI)      diff_sat = SAT_HI;
        else if (diff < SAT_LO) diff_sat = SAT_LO;
        else                    diff_sat = diff;

        st_d = st_q;
        if (clr_i) begin
            st_d.flags = '0;
        end
        if (sof_i) begin
            st_d.carry = diff_sat[CARRY_W-1:0];
            if (diff_sat > LIM_HI) st_d.flags.over  = 1'b1;
            if (diff_sat < LIM_LO) st_d.flags.under = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign send_o  = send_s[CNT_W-1:0];
    assign flags_o = st_q.flags;

    p_send_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && (min_i <= max_i)) |-> ((send_o >= min_i) && (send_o <= max_i)));

    p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable(st_q.carry));

    p_over_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags.over && !clr_i) |=> st_q.flags.over);

    p_under_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags.under && !clr_i) |=> st_q.flags.under);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !sof_i) |=> (!st_q.flags.over && !st_q.flags.under));

endmodule

// File: rtl/iso_byte_scaler.sv
module iso_byte_scaler #(
    parameter int CNT_W = 8,
    parameter int BPS_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sof_i,
    input  logic [CNT_W-1:0]       send_i,
    input  logic [BPS_W-1:0]       bps_i,
    output logic                   valid_o,
    output logic [CNT_W+BPS_W-1:0] bytes_o
);
    localparam int BYTES_W = CNT_W + BPS_W;

    typedef struct packed {
        logic               valid;
        logic [BYTES_W-1:0] bytes;
    } scale_state_t;

    scale_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = sof_i;
        if (sof_i) begin
            st_d.bytes = BYTES_W'(send_i) * BYTES_W'(bps_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign bytes_o = st_q.bytes;

    p_valid_after_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> valid_o);

    p_valid_only_after_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> !valid_o);

    p_zero_samples_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && send_i == '0) |=> (bytes_o == '0));

endmodule

// File: rtl/iso_packet_sizer.sv
module iso_packet_sizer
    import iso_sizer_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int BPS_W   = 3,
    parameter int CARRY_W = 6,
    parameter int LIMIT   = SLACK_LIMIT_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sof_i,
    input  logic                   smp_tick_i,
    input  logic [BPS_W-1:0]       bps_i,
    input  logic [CNT_W-1:0]       spp_min_i,
    input  logic [CNT_W-1:0]       spp_max_i,
    input  logic                   flag_clr_i,
    output logic                   pkt_valid_o,
    output logic [CNT_W+BPS_W-1:0] pkt_bytes_o,
    output logic                   overrun_o,
    output logic                   underrun_o
);
    logic [CNT_W-1:0] frame_cnt;
    logic [CNT_W-1:0] send_cnt;
    iso_flags_t       flags;

    iso_tick_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (sof_i),
        .tick_i  (smp_tick_i),
        .count_o (frame_cnt)
    );

    iso_carry_clamp #(
        .CNT_W   (CNT_W),
        .CARRY_W (CARRY_W),
        .LIMIT   (LIMIT)
    ) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (sof_i),
        .count_i (frame_cnt),
        .min_i   (spp_min_i),
        .max_i   (spp_max_i),
        .clr_i   (flag_clr_i),
        .send_o  (send_cnt),
        .flags_o (flags)
    );

    iso_byte_scaler #(.CNT_W(CNT_W), .BPS_W(BPS_W)) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (sof_i),
        .send_i  (send_cnt),
        .bps_i   (bps_i),
        .valid_o (pkt_valid_o),
        .bytes_o (pkt_bytes_o)
    );

    assign overrun_o  = flags.over;
    assign underrun_o = flags.under;

    p_flags_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!overrun_o && !underrun_o && !pkt_valid_o));

endmodule

// File: tb/iso_packet_sizer_bench.sv
`timescale 1ns/1ps
module iso_packet_sizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  bps = 3'd1;
    logic [7:0]  mn = 8'd7;
    logic [7:0]  mx = 8'd9;
    logic        clr = 1'b0;
    logic        valid;
    logic [10:0] bytes;
    logic        over;
    logic        under;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int m_carry = 0;
    int m_pend  = 0;
    bit m_over  = 0;
    bit m_under = 0;

    iso_packet_sizer u_iso_packet_sizer (
        .clk(clk), .rst_n(rst_n), .sof_i(sof), .smp_tick_i(tick),
        .bps_i(bps), .spp_min_i(mn), .spp_max_i(mx), .flag_clr_i(clr),
        .pkt_valid_o(valid), .pkt_bytes_o(bytes),
        .overrun_o(over), .underrun_o(under)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // one frame: nt sample strobes, then a start-of-frame cycle
    task automatic frame(int nt, bit tk, bit cl, string req);
        int acc; int avail; int send; int d;
        for (int i = 0; i < nt; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = tk; sof = 1'b1; clr = cl;
        acc = m_pend + nt;
        if (acc > 255) acc = 255;
        avail = acc + m_carry;
        if (avail > int'(mx))      send = int'(mx);
        else if (avail < int'(mn)) send = int'(mn);
        else                       send = avail;
        d = avail - send;
        if (d > 31)  d = 31;
        if (d < -31) d = -31;
        m_over  = (d > 2)  || (m_over  && !cl);
        m_under = (d < -2) || (m_under && !cl);
        m_carry = d;
        m_pend  = tk ? 1 : 0;
        @(negedge clk); sof = 1'b0; tick = 1'b0; clr = 1'b0;
        chk({req, " valid"}, int'(valid), 1);
        chk({req, " bytes"}, int'(bytes), send * int'(bps));
        chk({req, " over"}, int'(over), int'(m_over));
        chk({req, " under"}, int'(under), int'(m_under));
        @(negedge clk);
        chk("R2 valid single", int'(valid), 0);
    endtask

    task automatic clear_flags();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        m_over = 0; m_under = 0;
        chk("R9 over cleared", int'(over), 0);
        chk("R9 under cleared", int'(under), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(valid), 0);
        chk("R1 over", int'(over), 0);
        chk("R1 under", int'(under), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", int'(valid), 0);
        // R1: carry starts at zero, so an exact-nominal frame is sent unchanged
        bps = 3'd1; mn = 8'd7; mx = 8'd9;
        frame(8, 0, 0, "R1 R4");

        // sweep: two stream shapes, every bytes-per-sample from 1 to 4
        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int b = 1; b <= 4; b++) begin
                int base;
                base = (cfg == 0) ? 8 : 44;
                mn   = (cfg == 0) ? 8'd7 : 8'd43;
                mx   = (cfg == 0) ? 8'd9 : 8'd46;
                bps  = 3'(b);
                clear_flags();
                for (int f = 0; f < 20; f++) begin
                    frame(base + ((f * 7 + b) % 5) - 2, 0, 0, "R4 R6");
                end
            end
        end

        // overrun: too many samples per frame
        bps = 3'd1; mn = 8'd7; mx = 8'd9;
        clear_flags();
        frame(8, 0, 0, "R5");
        frame(14, 0, 0, "R7");
        frame(14, 0, 0, "R7");
        // a clear in the same cycle as a setting frame leaves the flag set
        frame(14, 0, 1, "R9");
        // carry saturation
        frame(60, 0, 0, "R5");
        frame(60, 0, 0, "R5");
        frame(0, 0, 0, "R5");
        frame(0, 0, 0, "R5");
        frame(0, 0, 0, "R5");
        frame(0, 0, 0, "R5");
        // underrun: starved frames
        clear_flags();
        frame(0, 0, 0, "R8");
        frame(0, 0, 0, "R8");
        frame(0, 0, 0, "R8");
        frame(3, 0, 0, "R8");
        // strobe coinciding with the frame mark belongs to the next frame
        clear_flags();
        mn = 8'd0; mx = 8'd20; bps = 3'd2;
        frame(30, 0, 0, "R3");
        frame(5, 1, 0, "R3");
        frame(5, 0, 0, "R3");
        frame(6, 1, 0, "R3");
        frame(0, 0, 0, "R3");
        // counter saturation
        mn = 8'd0; mx = 8'd255; bps = 3'd4;
        frame(300, 0, 0, "R10");
        frame(10, 0, 0, "R10");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule